// File: doc/BRIEF.md
# Three-Axis Sample Register Bank

This block keeps the latest X, Y and Z acceleration samples produced by a sampling engine and serves them to a byte-wide register read port. Each axis has two byte registers side by side in the address space. At read time the stored 16-bit sample is shaped into one of two formats. The first is a 12-bit value, right-justified and filled upward with its sign. The second is the full 16-bit value, left-justified. A run-time setting chooses which byte of the pair sits at the lower address.

A host reading the two halves of a sample one byte at a time can enable pair holding. Once one half of a pair has been read, that pair ignores new samples until the other half has also been read, so the two bytes always belong to the same sample. A data-ready pin tells the host when every enabled axis holds an unread sample, and drops once those bytes have been read. A select input can hand the same pin over to an interrupt line coming from elsewhere.

Top module: `accel_regbank`

## Requirements
- R1: After reset every mapped byte reads 00h and `readyPin` is 0.
- R2: The X pair sits at addresses 28h/29h, Y at 2Ah/2Bh and Z at 2Ch/2Dh. A request with `rdValid` high returns its byte on `rdData` one cycle later. Any other address returns 00h, and a cycle with no request is followed by 00h.
- R3: With `cfgSwapBytes`=0 the even address of a pair returns bits 7:0 of the formatted value and the odd address returns bits 15:8. With `cfgSwapBytes`=1 the two are exchanged.
- R4: With `cfgWideAlign`=0 the formatted value is bits 15:4 of the sample, sign-extended to 16 bits by copies of bit 15.
- R5: With `cfgWideAlign`=1 the formatted value is the 16-bit sample unchanged.
- R6: With `cfgHoldPair`=0 every `sampleValid` pulse overwrites all three pairs, even when only one half of a pair has been read.
- R7: With `cfgHoldPair`=1, reading one half of a pair blocks all later samples from that pair until its other half has been read. The pairs of other axes keep updating.
- R8: With `cfgHoldPair`=1, a sample pulse in the same cycle as a read of one half of a pair is not written into that pair, so the other half still matches the byte just returned.
- R9: With `cfgPinSelIrq`=0 and `cfgReadyEn`=0, `readyPin` is 0 whatever samples arrive.
- R10: With `cfgReadyEn`=1 and `cfgPinSelIrq`=0, `readyPin` goes to 1 no later than the second rising edge after each axis enabled in `axisEn` (bit 0 X, bit 1 Y, bit 2 Z) has received a sample into its pair. A disabled axis is not waited for, and a pair that rejected a sample because it was held does not count as new.
- R11: Once high, `readyPin` stays high while any byte of an enabled axis is still unread since its last sample. It returns to 0 within two rising edges after the last such byte is read.
- R12: With `cfgPinSelIrq`=1, `readyPin` follows `irqIn` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | One-cycle strobe marking a new X/Y/Z set |
| sampleX | input | 16 | X sample, two's complement |
| sampleY | input | 16 | Y sample, two's complement |
| sampleZ | input | 16 | Z sample, two's complement |
| cfgSwapBytes | input | 1 | 1: high byte at the lower address |
| cfgWideAlign | input | 1 | 0: 12-bit sign-extended, 1: 16-bit left-justified |
| cfgHoldPair | input | 1 | 1: hold a pair until both halves are read |
| cfgReadyEn | input | 1 | Enables data-ready on the pin |
| cfgPinSelIrq | input | 1 | 1: pin carries `irqIn` |
| axisEn | input | 3 | Axes that data-ready waits for |
| irqIn | input | 1 | Interrupt from outside logic |
| rdValid | input | 1 | Single-cycle read request |
| rdAddr | input | 6 | Read byte address |
| rdData | output | 8 | Read byte, one cycle after the request |
| readyPin | output | 1 | Data-ready or interrupt pin |

## Verification
The bench sweeps sample values that include the sign-bit boundaries 7FFFh, 8000h and FFFFh across both byte orders and both alignments. This catches a formatter that sign-extends from the wrong bit or a byte lane that is swapped the wrong way. It reads one half of a pair, pushes new samples, and then reads the other half. A bank without holding, or one that forgets to release a pair, returns a byte from the wrong sample. A read in the same cycle as a sample pulse is exercised to expose torn pairs. Data-ready is driven with Z disabled and with one pair held, so a flag that waits on disabled axes, counts a rejected sample, or drops after a partial read shows the wrong pin level.

// File: rtl/accel_regbank_pkg.sv
package accel_regbank_pkg;
  localparam int AXES     = 3;
  localparam int ADDR_W   = 6;
  localparam int AXIS_W   = $clog2(AXES);
  localparam logic [ADDR_W-1:0] MAP_BASE = 6'h28;

  typedef struct packed {
    logic [AXES-1:0] loadAxis;
  } bankStrobeT;

  function automatic logic mapHit(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - MAP_BASE;
    return (a >= MAP_BASE) && (off < ADDR_W'(2 * AXES));
  endfunction

  function automatic logic [AXIS_W-1:0] mapAxis(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - MAP_BASE;
    return off[AXIS_W:1];
  endfunction

  function automatic logic mapHalf(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - MAP_BASE;
    return off[0];
  endfunction
endpackage

// File: rtl/accel_regbank_ctrl.sv
module accel_regbank_ctrl
  import accel_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              cfgHoldPair,
  input  logic              cfgReadyEn,
  input  logic              cfgPinSelIrq,
  input  logic [AXES-1:0]   axisEn,
  input  logic              irqIn,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  output bankStrobeT        strobe,
  output logic              readyPin
);
  logic              rdHit;
  logic [AXIS_W-1:0] rdAxis;
  logic              rdHalf;
  logic [AXES-1:0][1:0] readNow;
  logic [AXES-1:0][1:0] halfSeen;
  logic [AXES-1:0][1:0] pend;
  logic [AXES-1:0]   frozen;
  logic [AXES-1:0]   axisNew;
  logic              allNew;
  logic              noneNew;
  logic              readyState;

  assign rdHit  = mapHit(rdAddr);
  assign rdAxis = mapAxis(rdAddr);
  assign rdHalf = mapHalf(rdAddr);

  genvar gi;
  generate
    for (gi = 0; gi < AXES; gi++) begin : gAxis
      always_comb begin
        readNow[gi] = 2'b00;
        if (rdValid && rdHit && (rdAxis == AXIS_W'(gi)))
          readNow[gi][rdHalf] = 1'b1;
      end

      assign frozen[gi]          = cfgHoldPair && (halfSeen[gi] != 2'b00);
      assign strobe.loadAxis[gi] = sampleValid &&
                                   !(cfgHoldPair && (frozen[gi] || (readNow[gi] != 2'b00)));
      assign axisNew[gi]         = |pend[gi];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          halfSeen[gi] <= 2'b00;
        end else if (!cfgHoldPair) begin
          halfSeen[gi] <= 2'b00;
        end else if (&(halfSeen[gi] | readNow[gi])) begin
          halfSeen[gi] <= 2'b00;
        end else begin
          halfSeen[gi] <= halfSeen[gi] | readNow[gi];
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                    pend[gi] <= 2'b00;
        else if (strobe.loadAxis[gi]) pend[gi] <= 2'b11;
        else                          pend[gi] <= pend[gi] & ~readNow[gi];
      end

      // R7
      held_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
        (cfgHoldPair && halfSeen[gi] != 2'b00) |-> !strobe.loadAxis[gi]);
    end
  endgenerate

  assign allNew  = (|axisEn) && (&(axisNew | ~axisEn));
  assign noneNew = ~|(axisNew & axisEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        readyState <= 1'b0;
    else if (allNew)  readyState <= 1'b1;
    else if (noneNew) readyState <= 1'b0;
  end

  assign readyPin = cfgPinSelIrq ? irqIn : (cfgReadyEn & readyState);

  // R6
  load_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe.loadAxis) |-> sampleValid);
  // R10
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyState) |-> $past(|axisEn));
  // R9
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgPinSelIrq && !cfgReadyEn) |-> !readyPin);
  // R12
  pin_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgPinSelIrq |-> (readyPin == irqIn));
endmodule

// File: rtl/accel_regbank_dp.sv
module accel_regbank_dp
  import accel_regbank_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int NARROW_W = 12,
  parameter int DATA_W   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bankStrobeT                    strobe,
  input  logic [AXES-1:0][SAMPLE_W-1:0] sampleIn,
  input  logic                          cfgSwapBytes,
  input  logic                          cfgWideAlign,
  input  logic                          rdValid,
  input  logic [ADDR_W-1:0]             rdAddr,
  output logic [DATA_W-1:0]             rdData
);
  localparam int EXT_W = SAMPLE_W - NARROW_W;

  logic [AXES-1:0][SAMPLE_W-1:0] store;
  logic [AXES-1:0][SAMPLE_W-1:0] shaped;
  logic              rdHit;
  logic [AXIS_W-1:0] rdAxis;
  logic              highSel;
  logic [DATA_W-1:0] byteOut;

  genvar gi;
  generate
    for (gi = 0; gi < AXES; gi++) begin : gStore
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                    store[gi] <= '0;
        else if (strobe.loadAxis[gi]) store[gi] <= sampleIn[gi];
      end

      assign shaped[gi] = cfgWideAlign ? store[gi]
                        : {{EXT_W{store[gi][SAMPLE_W-1]}}, store[gi][SAMPLE_W-1 -: NARROW_W]};

      // R7
      store_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.loadAxis[gi] |=> $stable(store[gi]));
    end
  endgenerate

  assign rdHit   = mapHit(rdAddr);
  assign rdAxis  = mapAxis(rdAddr);
  assign highSel = mapHalf(rdAddr) ^ cfgSwapBytes;

  always_comb begin
    byteOut = '0;
    for (int i = 0; i < AXES; i++) begin
      if (rdAxis == AXIS_W'(i))
        byteOut = highSel ? shaped[i][2*DATA_W-1 -: DATA_W] : shaped[i][DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rdData <= '0;
    else if (rdValid && rdHit) rdData <= byteOut;
    else                      rdData <= '0;
  end

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdValid) |-> (rdData == '0));
endmodule

// File: rtl/accel_regbank.sv
module accel_regbank
  import accel_regbank_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int NARROW_W = 12,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleX,
  input  logic [SAMPLE_W-1:0] sampleY,
  input  logic [SAMPLE_W-1:0] sampleZ,
  input  logic                cfgSwapBytes,
  input  logic                cfgWideAlign,
  input  logic                cfgHoldPair,
  input  logic                cfgReadyEn,
  input  logic                cfgPinSelIrq,
  input  logic [AXES-1:0]     axisEn,
  input  logic                irqIn,
  input  logic                rdValid,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  output logic                readyPin
);
  bankStrobeT                    strobe;
  logic [AXES-1:0][SAMPLE_W-1:0] sampleIn;

  assign sampleIn = {sampleZ, sampleY, sampleX};

  accel_regbank_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .cfgHoldPair(cfgHoldPair), .cfgReadyEn(cfgReadyEn), .cfgPinSelIrq(cfgPinSelIrq),
    .axisEn(axisEn), .irqIn(irqIn), .rdValid(rdValid), .rdAddr(rdAddr),
    .strobe(strobe), .readyPin(readyPin)
  );

  accel_regbank_dp #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleIn(sampleIn),
    .cfgSwapBytes(cfgSwapBytes), .cfgWideAlign(cfgWideAlign),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/accel_regbank_test.sv
`timescale 1ns/1ps
module accel_regbank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleX = '0, sampleY = '0, sampleZ = '0;
  logic        cfgSwapBytes = 1'b0, cfgWideAlign = 1'b0, cfgHoldPair = 1'b0;
  logic        cfgReadyEn = 1'b0, cfgPinSelIrq = 1'b0, irqIn = 1'b0;
  logic [2:0]  axisEn = 3'b111;
  logic        rdValid = 1'b0;
  logic [5:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic        readyPin;
  int nTests = 0, nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  accel_regbank uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleX(sampleX), .sampleY(sampleY), .sampleZ(sampleZ),
    .cfgSwapBytes(cfgSwapBytes), .cfgWideAlign(cfgWideAlign), .cfgHoldPair(cfgHoldPair),
    .cfgReadyEn(cfgReadyEn), .cfgPinSelIrq(cfgPinSelIrq), .axisEn(axisEn), .irqIn(irqIn),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdData(rdData), .readyPin(readyPin)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] shapeVal(input logic [15:0] s, input logic wide);
    return wide ? s : {{4{s[15]}}, s[15:4]};
  endfunction

  function automatic logic [7:0] expByte(input logic [5:0] a, input logic [15:0] x,
                                         input logic [15:0] y, input logic [15:0] z,
                                         input logic swap, input logic wide);
    logic [15:0] v;
    logic hi;
    if (a < 6'h28 || a > 6'h2D) return 8'h00;
    case ((a - 6'h28) >> 1)
      0: v = shapeVal(x, wide);
      1: v = shapeVal(y, wide);
      default: v = shapeVal(z, wide);
    endcase
    hi = a[0] ^ swap;
    return hi ? v[15:8] : v[7:0];
  endfunction

  task automatic loadSample(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
    @(negedge clk);
    sampleValid = 1'b1; sampleX = x; sampleY = y; sampleZ = z;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic readByte(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    rdValid = 1'b1; rdAddr = a;
    @(negedge clk);
    rdValid = 1'b0;
    d = rdData;
  endtask

  task automatic drainAll();
    logic [7:0] d;
    for (int a = 6'h28; a <= 6'h2D; a++) readByte(6'(a), d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    if (!finished) $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [15:0] x, y, z;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1 pin", 16'(readyPin), 16'h0);
    for (int a = 6'h28; a <= 6'h2D; a++) begin
      readByte(6'(a), d);
      chk("R1 byte", 16'(d), 16'h00);
    end

    // R3 R4 R5 R2: sweep values, byte orders, alignments
    for (int sw = 0; sw < 2; sw++) begin
      for (int wd = 0; wd < 2; wd++) begin
        cfgSwapBytes = sw[0]; cfgWideAlign = wd[0];
        for (int v = 0; v < 32; v++) begin
          x = (v == 0) ? 16'h0000 : (v == 1) ? 16'h7FFF : (v == 2) ? 16'h8000 :
              (v == 3) ? 16'hFFFF : 16'(v * 16'h9E37);
          y = x ^ 16'h5A5A; z = ~x;
          loadSample(x, y, z);
          for (int a = 6'h28; a <= 6'h2D; a++) begin
            readByte(6'(a), d);
            chk(wd ? "R5 R3 wide byte" : "R4 R3 narrow byte", 16'(d),
                16'(expByte(6'(a), x, y, z, sw[0], wd[0])));
          end
        end
      end
    end

    // R2: unmapped addresses and idle cycle
    cfgSwapBytes = 1'b0; cfgWideAlign = 1'b1;
    loadSample(16'hA5C3, 16'h1234, 16'hFEDC);
    readByte(6'h27, d); chk("R2 below map", 16'(d), 16'h00);
    readByte(6'h2E, d); chk("R2 above map", 16'(d), 16'h00);
    readByte(6'h00, d); chk("R2 zero addr", 16'(d), 16'h00);
    @(negedge clk); chk("R2 idle", 16'(rdData), 16'h00);

    // R6: no holding, half-read pair still overwritten
    cfgHoldPair = 1'b0;
    loadSample(16'h1111, 16'h2222, 16'h3333);
    readByte(6'h28, d); chk("R6 lo", 16'(d), 16'h11);
    loadSample(16'hABCD, 16'h2222, 16'h3333);
    readByte(6'h29, d); chk("R6 hi new", 16'(d), 16'hAB);

    // R7: holding
    cfgHoldPair = 1'b1;
    drainAll();
    loadSample(16'h4C21, 16'h5D32, 16'h6E43);
    readByte(6'h28, d); chk("R7 lo A", 16'(d), 16'h21);
    loadSample(16'h9F87, 16'h7A65, 16'h8B76);
    readByte(6'h2B, d); chk("R7 other axis updates", 16'(d), 16'h7A);
    readByte(6'h2A, d); chk("R7 other axis lo", 16'(d), 16'h65);
    readByte(6'h29, d); chk("R7 held hi", 16'(d), 16'h4C);
    loadSample(16'hC3B2, 16'h0102, 16'h0304);
    readByte(6'h28, d); chk("R7 released lo", 16'(d), 16'hB2);
    readByte(6'h29, d); chk("R7 released hi", 16'(d), 16'hC3);

    // R8: read and sample in the same cycle
    @(negedge clk);
    sampleValid = 1'b1; sampleX = 16'hE1E2; sampleY = 16'hF1F2; sampleZ = 16'hD1D2;
    rdValid = 1'b1; rdAddr = 6'h2A;
    @(negedge clk);
    sampleValid = 1'b0; rdValid = 1'b0;
    chk("R8 lo old", 16'(rdData), 16'h02);
    readByte(6'h2B, d); chk("R8 hi old", 16'(d), 16'h01);
    readByte(6'h28, d); chk("R8 X took sample", 16'(d), 16'hE2);
    readByte(6'h29, d);

    // R9: enable off
    drainAll();
    cfgReadyEn = 1'b0;
    loadSample(16'h1000, 16'h2000, 16'h3000);
    repeat (3) @(negedge clk);
    chk("R9 pin off", 16'(readyPin), 16'h0);

    // R10 R11: Z disabled
    drainAll();
    cfgReadyEn = 1'b1; axisEn = 3'b011;
    repeat (2) @(negedge clk);
    chk("R11 drained low", 16'(readyPin), 16'h0);
    loadSample(16'h1000, 16'h2000, 16'h3000);
    @(negedge clk);
    chk("R10 rise Z off", 16'(readyPin), 16'h1);
    readByte(6'h28, d); readByte(6'h29, d); readByte(6'h2A, d);
    repeat (2) @(negedge clk);
    chk("R11 partial stays", 16'(readyPin), 16'h1);
    readByte(6'h2B, d);
    @(negedge clk);
    chk("R11 fall", 16'(readyPin), 16'h0);

    // R10: held pair rejects sample, no rise
    axisEn = 3'b111;
    drainAll();
    readByte(6'h28, d);
    loadSample(16'h4444, 16'h5555, 16'h6666);
    repeat (2) @(negedge clk);
    chk("R10 held pair no rise", 16'(readyPin), 16'h0);
    readByte(6'h29, d);
    loadSample(16'h7777, 16'h8888, 16'h9999);
    @(negedge clk);
    chk("R10 all new rise", 16'(readyPin), 16'h1);

    // R12: pin select
    cfgPinSelIrq = 1'b1; irqIn = 1'b0;
    #1 chk("R12 irq low", 16'(readyPin), 16'h0);
    @(negedge clk); irqIn = 1'b1;
    #1 chk("R12 irq high", 16'(readyPin), 16'h1);
    cfgReadyEn = 1'b0;
    #1 chk("R12 irq ignores enable", 16'(readyPin), 16'h1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule